// File: doc/BRIEF.md
# Dual and Quad Fast-Read Data Path

This block is the read side of a serial NOR flash target. It handles the fast reads that move address and data over two or four I/O lines. It runs in the target's system clock domain. SCLK arrives as two single-cycle strobes, one for the rising edge and one for the falling edge. The chip-select is active low. A separate opcode decoder reports which read was requested with a one-cycle pulse and a two-bit kind code.

Once a read has started, the block collects the interleaved address and mode bits from the lines. It counts out any dummy clocks. It then fetches bytes through a combinational byte-wide memory port and shifts each byte onto the lines on falling SCLK edges. The address steps forward while chip-select stays low. The block drives the output enables only while data is being driven.

A mode byte whose bits 5:4 equal binary 10 arms a continuous read. The next transaction then starts with the address directly, with no opcode, and uses the same read kind. Any other mode value disarms it.

Top module: `qrd_fast_read_engine`

## Requirements
- R1: After reset, `io_oe` is 0 and `cont_armed` is 0. A chip-select falling edge with the block disarmed makes it wait for `cmd_valid` and drive nothing.
- R2: Kind code 0 is the dual read. On each of 16 rising SCLK strobes it takes `io_in[1]` as the higher bit and `io_in[0]` as the lower bit, MSB first. This forms a 24-bit address followed by an 8-bit mode byte. No dummy clocks follow.
- R3: Dual data: each byte takes 4 falling strobes. Slot s drives `io_out[1]` = D(7-2s) and `io_out[0]` = D(6-2s). `io_oe` is 4'b0011.
- R4: Kind code 1 is the quad read. On each of 8 rising strobes it takes `io_in[3:0]` as a nibble, MSB first: six address nibbles, then two mode nibbles. Four dummy clocks follow.
- R5: Quad data: each byte takes 2 falling strobes. The high nibble goes out first on `io_out[3:0]`, then the low nibble. `io_oe` is 4'b1111.
- R6: Kind code 2 is the quad word read. It gathers its frame the same way as the quad read and forces address bit 0 to 0. Two dummy clocks follow.
- R7: The first data slot goes out on the falling strobe that ends the last address or dummy clock. The memory address then increments by one per byte while chip-select stays low, and wraps after 2^24-1.
- R8: A mode byte with bits 5:4 = 2'b10 sets `cont_armed`. The next transaction then takes its address at once, in the same kind, with no `cmd_valid`. Any other mode value clears `cont_armed`.
- R9: `io_oe` is nonzero only during the data phase. It returns to 0 combinationally, in the same cycle that `cs_n` goes high.
- R10: Reset clears `cont_armed`. A following transaction then waits for a command.
- R11: A `cmd_valid` pulse with kind code 3 is ignored: no data phase follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip-select, active low |
| sclk_rise | input | 1 | One-cycle strobe for a rising SCLK edge |
| sclk_fall | input | 1 | One-cycle strobe for a falling SCLK edge |
| cmd_valid | input | 1 | Decoded read command pulse |
| cmd_kind | input | 2 | 0 dual, 1 quad, 2 quad word, 3 none |
| io_in | input | 4 | Sampled I/O lines |
| mem_rdata | input | 8 | Byte at `mem_addr` (combinational read) |
| mem_addr | output | 24 | Current read address |
| io_out | output | 4 | Output values for the I/O lines |
| io_oe | output | 4 | Output enables for the I/O lines |
| cont_armed | output | 1 | Continuous-read shortcut armed |

## Verification
On every cycle, the embedded properties check several things. The address counter stays inside the frame length. The data phase begins only on a rising strobe. Every completed byte advances the address by exactly one. A word read always starts on an even address. A mode byte without the 10 pattern leaves the shortcut disarmed.

Other behaviours are visible only through the bench's scenarios against its reference model:
- the bit interleave on the lines;
- the exact slot in which each output bit appears;
- the wrap at the top of the address space;
- command-less restarts in both dual and quad reads;
- the effect of a reset on an armed shortcut;
- an ignored command kind.

// File: rtl/qrd_pkg.sv
package qrd_pkg;

  typedef enum logic [1:0] {
    RK_DUAL = 2'd0,
    RK_QUAD = 2'd1,
    RK_WORD = 2'd2,
    RK_NONE = 2'd3
  } rd_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAITCMD,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA
  } rd_state_e;

  // Index of the final output slot of a byte.
  function automatic logic [1:0] last_slot(input rd_kind_e k);
    return (k == RK_DUAL) ? 2'd3 : 2'd1;
  endfunction

  // Output enable pattern used during the data phase.
  function automatic logic [3:0] oe_mask(input rd_kind_e k);
    return (k == RK_DUAL) ? 4'b0011 : 4'b1111;
  endfunction

  // Bits driven on the lines for a given slot, MSB first.
  function automatic logic [3:0] lane_slice(input logic [7:0] b, input rd_kind_e k,
                                            input logic [1:0] slot);
    if (k == RK_DUAL) return {2'b00, 2'(b >> (3'd6 - {slot, 1'b0}))};
    return 4'(b >> (4'd4 - {slot, 2'b00}));
  endfunction

endpackage

// File: rtl/qrd_addr_deser.sv
module qrd_addr_deser
  import qrd_pkg::*;
#(
  parameter int ADDR_W = 24,
  localparam int FRAME_W = ADDR_W + 8,
  localparam int CW = $clog2(FRAME_W / 2 + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              sclk_rise,
  input  rd_kind_e          kind,
  input  logic [3:0]        io_in,
  output logic              frame_done,
  output logic [ADDR_W-1:0] frame_addr,
  output logic [1:0]        cont_code
);
  logic [FRAME_W-1:0] sr_q, sr_next;
  logic [CW-1:0]      cnt_q, last_cnt;

  always_comb begin
    if (kind == RK_DUAL) begin
      sr_next  = {sr_q[FRAME_W-3:0], io_in[1:0]};
      last_cnt = CW'(FRAME_W / 2 - 1);
    end else begin
      sr_next  = {sr_q[FRAME_W-5:0], io_in};
      last_cnt = CW'(FRAME_W / 4 - 1);
    end
  end

  assign frame_done = active & sclk_rise & (cnt_q == last_cnt);
  assign frame_addr = sr_next[FRAME_W-1:8];
  assign cont_code  = sr_next[5:4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sr_q  <= '0;
    end else if (!active) begin
      cnt_q <= '0;
    end else if (sclk_rise) begin
      cnt_q <= cnt_q + 1'b1;
      sr_q  <= sr_next;
    end
  end

  assert_cnt_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt_q <= last_cnt));

endmodule

// File: rtl/qrd_data_ser.sv
module qrd_data_ser
  import qrd_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] start_addr,
  input  rd_kind_e          kind,
  input  logic              data_active,
  input  logic              sclk_fall,
  input  logic [7:0]        mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        io_out,
  output logic              byte_done
);
  logic [ADDR_W-1:0] ptr_q;
  logic [1:0]        slot_q;
  logic [7:0]        byte_q, cur_byte;
  logic [3:0]        out_q;

  assign cur_byte  = (slot_q == 2'd0) ? mem_rdata : byte_q;
  assign byte_done = data_active & sclk_fall & (slot_q == last_slot(kind));
  assign mem_addr  = ptr_q;
  assign io_out    = out_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      slot_q <= '0;
      byte_q <= '0;
      out_q  <= '0;
    end else if (load) begin
      ptr_q  <= start_addr;
      slot_q <= '0;
    end else if (data_active && sclk_fall) begin
      out_q <= lane_slice(cur_byte, kind, slot_q);
      if (slot_q == 2'd0) byte_q <= mem_rdata;
      if (slot_q == last_slot(kind)) begin
        slot_q <= '0;
        ptr_q  <= ptr_q + 1'b1;
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end

  assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

  assert_word_even_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && kind == RK_WORD) |=> (mem_addr[0] == 1'b0));

endmodule

// File: rtl/qrd_ctrl.sv
module qrd_ctrl
  import qrd_pkg::*;
#(
  parameter int DUMMY_QUAD = 4,
  parameter int DUMMY_WORD = 2,
  localparam int DMAX = (DUMMY_QUAD > DUMMY_WORD) ? DUMMY_QUAD : DUMMY_WORD,
  localparam int DCW = $clog2(DMAX + 1)
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cs_n,
  input  logic     sclk_rise,
  input  logic     cmd_valid,
  input  rd_kind_e cmd_kind,
  input  logic     frame_done,
  input  logic [1:0] cont_code,
  output logic     addr_active,
  output logic     data_active,
  output rd_kind_e kind,
  output logic     armed
);
  rd_state_e st_q;
  rd_kind_e  kind_q, armed_kind_q;
  logic      armed_q, cs_q, cs_fall;
  logic [DCW-1:0] dcnt_q, dlen;

  assign cs_fall     = cs_q & ~cs_n;
  assign addr_active = (st_q == ST_ADDR) & ~cs_n;
  assign data_active = (st_q == ST_DATA) & ~cs_n;
  assign kind        = kind_q;
  assign armed       = armed_q;

  always_comb begin
    case (kind_q)
      RK_QUAD: dlen = DCW'(DUMMY_QUAD);
      RK_WORD: dlen = DCW'(DUMMY_WORD);
      default: dlen = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      kind_q       <= RK_DUAL;
      armed_kind_q <= RK_DUAL;
      armed_q      <= 1'b0;
      cs_q         <= 1'b1;
      dcnt_q       <= '0;
    end else begin
      cs_q <= cs_n;
      if (frame_done) begin
        armed_q      <= (cont_code == 2'b10);
        armed_kind_q <= kind_q;
      end
      if (cs_n) begin
        st_q <= ST_IDLE;
      end else begin
        case (st_q)
          ST_IDLE: if (cs_fall) begin
            if (armed_q) begin
              st_q   <= ST_ADDR;
              kind_q <= armed_kind_q;
            end else begin
              st_q <= ST_WAITCMD;
            end
          end
          ST_WAITCMD: if (cmd_valid && cmd_kind != RK_NONE) begin
            st_q   <= ST_ADDR;
            kind_q <= cmd_kind;
          end
          ST_ADDR: if (frame_done) begin
            dcnt_q <= '0;
            st_q   <= (dlen == '0) ? ST_DATA : ST_DUMMY;
          end
          ST_DUMMY: if (sclk_rise) begin
            if (dcnt_q == dlen - 1'b1) st_q <= ST_DATA;
            else dcnt_q <= dcnt_q + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assert_disarm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && cont_code != 2'b10) |=> !armed);

  assert_data_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_active) |-> $past(sclk_rise));

endmodule

// File: rtl/qrd_fast_read_engine.sv
module qrd_fast_read_engine
  import qrd_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DUMMY_QUAD = 4,
  parameter int DUMMY_WORD = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_kind,
  input  logic [3:0]        io_in,
  input  logic [7:0]        mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  output logic              cont_armed
);
  logic              addr_active, data_active, frame_done, byte_done;
  logic [ADDR_W-1:0] frame_addr, start_addr;
  logic [1:0]        cont_code;
  rd_kind_e          kind;

  qrd_ctrl #(.DUMMY_QUAD(DUMMY_QUAD), .DUMMY_WORD(DUMMY_WORD)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk_rise(sclk_rise),
    .cmd_valid(cmd_valid), .cmd_kind(rd_kind_e'(cmd_kind)),
    .frame_done(frame_done), .cont_code(cont_code),
    .addr_active(addr_active), .data_active(data_active),
    .kind(kind), .armed(cont_armed)
  );

  qrd_addr_deser #(.ADDR_W(ADDR_W)) u_deser (
    .clk(clk), .rst_n(rst_n), .active(addr_active), .sclk_rise(sclk_rise),
    .kind(kind), .io_in(io_in), .frame_done(frame_done),
    .frame_addr(frame_addr), .cont_code(cont_code)
  );

  // Word reads ignore the least significant address bit.
  assign start_addr = {frame_addr[ADDR_W-1:1], frame_addr[0] & (kind != RK_WORD)};

  qrd_data_ser #(.ADDR_W(ADDR_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .load(frame_done), .start_addr(start_addr),
    .kind(kind), .data_active(data_active), .sclk_fall(sclk_fall),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .io_out(io_out),
    .byte_done(byte_done)
  );

  assign io_oe = data_active ? oe_mask(kind) : 4'b0000;

  assert_oe_when_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe != 4'b0000) |-> !addr_active);

endmodule

// File: tb/tb_qrd_fast_read_engine.sv
module tb_qrd_fast_read_engine;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0, cs_n = 1'b1, sclk_rise = 1'b0, sclk_fall = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_kind = 2'd0;
  logic [3:0]  io_in = 4'd0;
  logic [7:0]  mem_rdata;
  logic [23:0] mem_addr;
  logic [3:0]  io_out, io_oe;
  logic        cont_armed;
  int total = 0, bad = 0;

  qrd_fast_read_engine dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .io_in(io_in), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .io_out(io_out), .io_oe(io_oe), .cont_armed(cont_armed)
  );

  function automatic logic [7:0] mem_model(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction
  assign mem_rdata = mem_model(mem_addr);

  // Reference line values for a slot.
  function automatic logic [3:0] ref_lines(input logic [7:0] b, input int kind, input int slot);
    logic [3:0] r = 4'd0;
    if (kind == 0) begin
      r[1] = b[7 - 2 * slot];
      r[0] = b[6 - 2 * slot];
    end else begin
      for (int i = 0; i < 4; i++) r[i] = b[(slot == 0 ? 4 : 0) + i];
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sclk_cycle(input logic [3:0] bits);
    io_in = bits;
    sclk_rise = 1'b1; @(negedge clk); sclk_rise = 1'b0; @(negedge clk);
    sclk_fall = 1'b1; @(negedge clk); sclk_fall = 1'b0; @(negedge clk);
  endtask

  task automatic send_cmd(input logic [1:0] k);
    for (int i = 0; i < 8; i++) begin
      sclk_cycle(4'd0);
      check(io_oe == 4'd0, "R1 oe during opcode", io_oe, 0);
    end
    cmd_kind = k; cmd_valid = 1'b1; @(negedge clk); cmd_valid = 1'b0; @(negedge clk);
  endtask

  task automatic run_read(input int kind, input logic [23:0] addr, input logic [7:0] mode,
                          input bit with_cmd, input int nbytes, input string req);
    logic [31:0] frame = {addr, mode};
    int lanes = (kind == 0) ? 2 : 4;
    int ac = 32 / lanes;
    int dum = (kind == 0) ? 0 : (kind == 1) ? 4 : 2;
    int slots = (kind == 0) ? 4 : 2;
    int p = ac + dum;
    logic [23:0] eff = addr;
    logic [3:0] mask = (kind == 0) ? 4'b0011 : 4'b1111;
    if (kind == 2) eff[0] = 1'b0;
    cs_n = 1'b0; @(negedge clk); @(negedge clk);
    if (with_cmd) send_cmd(2'(kind));
    for (int c = 0; c < p + nbytes * slots - 1; c++) begin
      logic [3:0] bits = 4'd0;
      if (c < ac) bits = 4'((frame >> (32 - lanes * (c + 1))) & ((1 << lanes) - 1));
      sclk_cycle(bits);
      if (c >= p - 1) begin
        int k = c - (p - 1);
        logic [7:0] b = mem_model(24'(eff + 24'(k / slots)));
        logic [3:0] exp = ref_lines(b, kind, k % slots);
        check(io_oe == mask, {req, " oe"}, io_oe, mask);
        check((io_out & io_oe) == exp, {req, " data"}, io_out & io_oe, exp);
      end else begin
        check(io_oe == 4'd0, "R9 oe before data", io_oe, 0);
      end
    end
    cs_n = 1'b1; #1;
    check(io_oe == 4'd0, "R9 release at cs high", io_oe, 0);
    @(negedge clk); @(negedge clk);
    check(cont_armed == (mode[5:4] == 2'b10), "R8 armed state", cont_armed, mode[5:4] == 2'b10);
  endtask

  task automatic idle_open(input int n, input string req);
    cs_n = 1'b0; @(negedge clk); @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sclk_cycle(4'hF);
      check(io_oe == 4'd0, req, io_oe, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; @(negedge clk);
    check(io_oe == 4'd0, "R1 reset oe", io_oe, 0);
    check(cont_armed == 1'b0, "R1 reset armed", cont_armed, 0);
    run_read(0, 24'h123456, 8'h00, 1'b1, 3, "R2 R3 dual");
    run_read(1, 24'hFFFFFE, 8'h20, 1'b1, 3, "R4 R5 R7 quad wrap");
    run_read(1, 24'h00ABCD, 8'hFF, 1'b0, 2, "R8 quad continuous");
    run_read(2, 24'h000101, 8'h00, 1'b1, 2, "R6 word");
    run_read(0, 24'h00F0F0, 8'hA5, 1'b1, 2, "R3 dual arm");
    run_read(0, 24'h000333, 8'h20, 1'b0, 1, "R8 dual continuous");
    rst_n = 1'b0; @(negedge clk); @(negedge clk); rst_n = 1'b1; @(negedge clk);
    check(cont_armed == 1'b0, "R10 reset disarms", cont_armed, 0);
    idle_open(20, "R10 no shortcut after reset");
    cs_n = 1'b1; @(negedge clk); @(negedge clk);
    cs_n = 1'b0; @(negedge clk); @(negedge clk);
    send_cmd(2'd3);
    for (int i = 0; i < 24; i++) begin
      sclk_cycle(4'hA);
      check(io_oe == 4'd0, "R11 kind 3 ignored", io_oe, 0);
    end
    cs_n = 1'b1; @(negedge clk); @(negedge clk);
    run_read(1, 24'h000040, 8'h00, 1'b1, 1, "R5 quad after ignore");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule